// File: doc/BRIEF.md
# Banked CPU Register File

This block is the programmer-visible register store of an 8-bit processor core. The core uses it for operands, addresses and control state. It holds:

- an accumulator and a flag byte;
- six general bytes, grouped into three pairs;
- a full alternate copy of those eight bytes;
- two 16-bit index words, a stack pointer and a program counter;
- an internal address-tracking word;
- an interrupt vector base byte and a refresh counter byte.

Decode logic outside the block drives the control inputs every cycle. One pair write and one byte write may land at the same clock edge. Two exchange commands swap different parts of the main bank with the alternate bank. The refresh counter can step on its own.

Reads are combinational. One 16-bit pair port and one 8-bit byte port each take a select code. A shared 2-bit index select makes the HL slot point at HL, IX or IY. The same index select steers the pair writes and byte writes that target that slot.

Top module: `cpu_regfile`

## Requirements
- R1: While `rst_n` is low, every register resets to zero, alternate bank included.
- R2: Pair select codes: 0 = A:F, 1 = B:C, 2 = D:E, 3 = indexed slot, 4 = SP, 5 = PC, 6 = address-tracking word, 7 = I:R. The first-named byte sits in bits 15:8 on `rd_pair`. A pair write with `pw_en` loads `pw_data[15:8]` into that byte and `pw_data[7:0]` into the second byte.
- R3: Byte select codes: 0 A, 1 F, 2 B, 3 C, 4 D, 5 E, 6 indexed-slot high, 7 indexed-slot low, 8 SP high, 9 SP low, 10 PC high, 11 PC low, 12 tracking high, 13 tracking low, 14 I, 15 R. A byte write with `bw_en` changes only the selected byte and keeps the other byte of its pair.
- R4: `idx_sel` maps the indexed slot (pair code 3, byte codes 6 and 7) to H:L when 0, IX when 1 and IY when 2 or 3. This holds for reads and for writes.
- R5: `xchg_af` swaps A and F with their alternates and leaves B, C, D, E, H and L unchanged.
- R6: `xchg_exx` swaps B, C, D, E, H and L with their alternates in one edge and leaves A and F unchanged.
- R7: When both exchange inputs are high in one cycle, all eight bytes are swapped.
- R8: When an exchange and a write land in the same cycle, the exchange happens first. The write then lands in the newly active main register, and the alternate receives the old main value.
- R9: F keeps all 8 written bits, with no bit masked.
- R10: `r_inc` adds one to bits 6:0 of R, wrapping within 7 bits, and leaves bit 7 unchanged. A write to R in the same cycle loads all 8 bits and wins over the increment.
- R11: When a pair write and a byte write target the same byte in one cycle, the byte write wins for that byte. The pair write still lands in the other byte.
- R12: A value written at a clock edge shows on the read ports during the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| idx_sel | input | 2 | Indexed-slot select: 0 HL, 1 IX, else IY |
| xchg_af | input | 1 | Swap A and F with their alternates |
| xchg_exx | input | 1 | Swap B, C, D, E, H, L with their alternates |
| pw_en | input | 1 | Pair write enable |
| pw_sel | input | 3 | Pair write select code |
| pw_data | input | 16 | Pair write data, first-named byte high |
| bw_en | input | 1 | Byte write enable |
| bw_sel | input | 4 | Byte write select code |
| bw_data | input | 8 | Byte write data |
| r_inc | input | 1 | Refresh counter step |
| rd_pair_sel | input | 3 | Pair read select code |
| rd_pair | output | 16 | Pair read data |
| rd_byte_sel | input | 4 | Byte read select code |
| rd_byte | output | 8 | Byte read data |

## Verification
The bench builds the block with its default 8-bit byte width. At that width the 7-bit refresh wrap is a single step from 0x7F or 0xFF, so it can be reached directly. Every select code, and every index value for the indexed slot, is read back after each operation. Random mixes of exchanges, same-cycle pair and byte writes and counter steps therefore exercise swap-then-write ordering and byte-over-pair priority against a bench-side model of all 28 bytes.

// File: rtl/cpu_regfile_pkg.sv
package cpu_regfile_pkg;

  localparam int NLANE  = 20;
  localparam int LANE_W = 5;
  localparam int NGPR   = 8;

  // storage lane numbering, shared by decoder and read mux
  localparam logic [LANE_W-1:0] L_A   = 5'd0;
  localparam logic [LANE_W-1:0] L_F   = 5'd1;
  localparam logic [LANE_W-1:0] L_B   = 5'd2;
  localparam logic [LANE_W-1:0] L_C   = 5'd3;
  localparam logic [LANE_W-1:0] L_D   = 5'd4;
  localparam logic [LANE_W-1:0] L_E   = 5'd5;
  localparam logic [LANE_W-1:0] L_H   = 5'd6;
  localparam logic [LANE_W-1:0] L_IXH = 5'd8;
  localparam logic [LANE_W-1:0] L_IYH = 5'd10;
  localparam logic [LANE_W-1:0] L_SPH = 5'd12;
  localparam logic [LANE_W-1:0] L_PCH = 5'd14;
  localparam logic [LANE_W-1:0] L_WZH = 5'd16;
  localparam logic [LANE_W-1:0] L_I   = 5'd18;
  localparam logic [LANE_W-1:0] L_R   = 5'd19;

  typedef enum logic [2:0] {
    PR_AF, PR_BC, PR_DE, PR_XY, PR_SP, PR_PC, PR_WZ, PR_IR
  } pair_code_e;

  typedef enum logic [3:0] {
    BY_A, BY_F, BY_B, BY_C, BY_D, BY_E, BY_XH, BY_XL,
    BY_SPH, BY_SPL, BY_PCH, BY_PCL, BY_WZH, BY_WZL, BY_I, BY_R
  } byte_code_e;

  function automatic logic [LANE_W-1:0] xy_hi_lane(input logic [1:0] idx);
    case (idx)
      2'd0:    return L_H;
      2'd1:    return L_IXH;
      default: return L_IYH;
    endcase
  endfunction

  function automatic logic [LANE_W-1:0] pair_hi_lane(input logic [2:0] code,
                                                      input logic [1:0] idx);
    case (pair_code_e'(code))
      PR_AF:   return L_A;
      PR_BC:   return L_B;
      PR_DE:   return L_D;
      PR_XY:   return xy_hi_lane(idx);
      PR_SP:   return L_SPH;
      PR_PC:   return L_PCH;
      PR_WZ:   return L_WZH;
      default: return L_I;
    endcase
  endfunction

  function automatic logic [LANE_W-1:0] pair_lo_lane(input logic [2:0] code,
                                                      input logic [1:0] idx);
    return pair_hi_lane(code, idx) + 5'd1;
  endfunction

  function automatic logic [LANE_W-1:0] byte_lane(input logic [3:0] code,
                                                   input logic [1:0] idx);
    case (byte_code_e'(code))
      BY_A:    return L_A;
      BY_F:    return L_F;
      BY_B:    return L_B;
      BY_C:    return L_C;
      BY_D:    return L_D;
      BY_E:    return L_E;
      BY_XH:   return xy_hi_lane(idx);
      BY_XL:   return xy_hi_lane(idx) + 5'd1;
      BY_SPH:  return L_SPH;
      BY_SPL:  return L_SPH + 5'd1;
      BY_PCH:  return L_PCH;
      BY_PCL:  return L_PCH + 5'd1;
      BY_WZH:  return L_WZH;
      BY_WZL:  return L_WZH + 5'd1;
      BY_I:    return L_I;
      default: return L_R;
    endcase
  endfunction

endpackage

// File: rtl/rf_write_decode.sv
module rf_write_decode
  import cpu_regfile_pkg::*;
#(
  parameter int W = 8
) (
  input  logic                         pw_en,
  input  logic [2:0]                   pw_sel,
  input  logic [2*W-1:0]               pw_data,
  input  logic                         bw_en,
  input  logic [3:0]                   bw_sel,
  input  logic [W-1:0]                 bw_data,
  input  logic [1:0]                   idx_sel,
  output logic [NLANE-1:0]             lane_we,
  output logic [NLANE-1:0][W-1:0]      lane_wd
);

  logic [LANE_W-1:0] p_hi, p_lo, b_ln;

  always_comb begin
    p_hi    = pair_hi_lane(pw_sel, idx_sel);
    p_lo    = pair_lo_lane(pw_sel, idx_sel);
    b_ln    = byte_lane(bw_sel, idx_sel);
    lane_we = '0;
    lane_wd = '0;
    if (pw_en) begin
      lane_we[p_hi] = 1'b1;
      lane_we[p_lo] = 1'b1;
      lane_wd[p_hi] = pw_data[2*W-1:W];
      lane_wd[p_lo] = pw_data[W-1:0];
    end
    // byte write overrides the pair write on a shared lane
    if (bw_en) begin
      lane_we[b_ln] = 1'b1;
      lane_wd[b_ln] = bw_data;
    end
  end

endmodule

// File: rtl/rf_gpr_banks.sv
module rf_gpr_banks
  import cpu_regfile_pkg::*;
#(
  parameter int W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     xchg_af,
  input  logic                     xchg_exx,
  input  logic [NGPR-1:0]          we,
  input  logic [NGPR-1:0][W-1:0]   wd,
  output logic [NGPR-1:0][W-1:0]   main_q
);

  logic [NGPR-1:0][W-1:0] alt_q, main_d, alt_d;
  logic [NGPR-1:0]        swap, en;

  for (genvar g = 0; g < NGPR; g++) begin : g_swap
    if (g < 2) begin : g_af
      assign swap[g] = xchg_af;
    end else begin : g_main
      assign swap[g] = xchg_exx;
    end
  end

  always_comb begin
    for (int i = 0; i < NGPR; i++) begin
      alt_d[i]  = swap[i] ? main_q[i] : alt_q[i];
      main_d[i] = we[i] ? wd[i] : (swap[i] ? alt_q[i] : main_q[i]);
      en[i]     = we[i] | swap[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      main_q <= '0;
      alt_q  <= '0;
    end else begin
      for (int i = 0; i < NGPR; i++) begin
        if (en[i]) begin
          main_q[i] <= main_d[i];
          alt_q[i]  <= alt_d[i];
        end
      end
    end
  end

  // R5
  af_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xchg_af && !we[1]) |=> (main_q[1] == $past(alt_q[1]) && alt_q[1] == $past(main_q[1])))
    else $error("F swap mismatch");

  // R5
  af_keeps_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xchg_af && !xchg_exx && !we[2]) |=> main_q[2] == $past(main_q[2]))
    else $error("B disturbed by AF swap");

  // R6
  exx_keeps_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xchg_exx && !xchg_af && !we[0]) |=> main_q[0] == $past(main_q[0]))
    else $error("A disturbed by EXX");

  // R6
  exx_swap_l_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xchg_exx && !we[7]) |=> (main_q[7] == $past(alt_q[7]) && alt_q[7] == $past(main_q[7])))
    else $error("L swap mismatch");

endmodule

// File: rtl/rf_word.sv
module rf_word #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we_hi,
  input  logic         we_lo,
  input  logic [W-1:0] wd_hi,
  input  logic [W-1:0] wd_lo,
  output logic [W-1:0] q_hi,
  output logic [W-1:0] q_lo
);

  logic [W-1:0] hi_d, lo_d;

  always_comb begin
    hi_d = we_hi ? wd_hi : q_hi;
    lo_d = we_lo ? wd_lo : q_lo;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_hi <= '0;
      q_lo <= '0;
    end else begin
      if (we_hi) q_hi <= hi_d;
      if (we_lo) q_lo <= lo_d;
    end
  end

  // R3
  keep_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we_hi && !we_lo) |=> (q_lo == $past(q_lo) && q_hi == $past(wd_hi)))
    else $error("low byte disturbed by high write");

  // R3
  keep_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we_lo && !we_hi) |=> (q_hi == $past(q_hi) && q_lo == $past(wd_lo)))
    else $error("high byte disturbed by low write");

endmodule

// File: rtl/rf_refresh.sv
module rf_refresh #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         i_we,
  input  logic [W-1:0] i_wd,
  input  logic         r_we,
  input  logic [W-1:0] r_wd,
  input  logic         r_inc,
  output logic [W-1:0] i_q,
  output logic [W-1:0] r_q
);

  localparam int CW = W - 1;

  logic [W-1:0]  i_d, r_d;
  logic [CW-1:0] r_step;
  logic          r_en;

  always_comb begin
    r_step = r_q[CW-1:0] + {{(CW-1){1'b0}}, 1'b1};
    i_d    = i_we ? i_wd : i_q;
    r_d    = r_we ? r_wd : {r_q[W-1], r_step};
    r_en   = r_we | r_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      i_q <= '0;
      r_q <= '0;
    end else begin
      if (i_we) i_q <= i_d;
      if (r_en) r_q <= r_d;
    end
  end

  // R10
  r_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (r_inc && !r_we) |=> (r_q[W-1] == $past(r_q[W-1]) &&
                          r_q[CW-1:0] == $past(r_q[CW-1:0]) + 1'b1))
    else $error("refresh step wrong");

  // R10
  r_wr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    r_we |=> r_q == $past(r_wd))
    else $error("refresh write lost");

endmodule

// File: rtl/cpu_regfile.sv
module cpu_regfile
  import cpu_regfile_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int PAIR_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        idx_sel,
  input  logic              xchg_af,
  input  logic              xchg_exx,
  input  logic              pw_en,
  input  logic [2:0]        pw_sel,
  input  logic [PAIR_W-1:0] pw_data,
  input  logic              bw_en,
  input  logic [3:0]        bw_sel,
  input  logic [BYTE_W-1:0] bw_data,
  input  logic              r_inc,
  input  logic [2:0]        rd_pair_sel,
  output logic [PAIR_W-1:0] rd_pair,
  input  logic [3:0]        rd_byte_sel,
  output logic [BYTE_W-1:0] rd_byte
);

  localparam int NWORD = (NLANE - NGPR - 2) / 2;

  logic [NLANE-1:0]             lane_we;
  logic [NLANE-1:0][BYTE_W-1:0] lane_wd;
  logic [NLANE-1:0][BYTE_W-1:0] lanes;

  rf_write_decode #(.W(BYTE_W)) u_dec (
    .pw_en   (pw_en),
    .pw_sel  (pw_sel),
    .pw_data (pw_data),
    .bw_en   (bw_en),
    .bw_sel  (bw_sel),
    .bw_data (bw_data),
    .idx_sel (idx_sel),
    .lane_we (lane_we),
    .lane_wd (lane_wd)
  );

  rf_gpr_banks #(.W(BYTE_W)) u_gpr (
    .clk      (clk),
    .rst_n    (rst_n),
    .xchg_af  (xchg_af),
    .xchg_exx (xchg_exx),
    .we       (lane_we[NGPR-1:0]),
    .wd       (lane_wd[NGPR-1:0]),
    .main_q   (lanes[NGPR-1:0])
  );

  // IX, IY, SP, PC and the address-tracking word
  for (genvar k = 0; k < NWORD; k++) begin : g_word
    localparam int HI = NGPR + 2 * k;
    rf_word #(.W(BYTE_W)) u_word (
      .clk   (clk),
      .rst_n (rst_n),
      .we_hi (lane_we[HI]),
      .we_lo (lane_we[HI+1]),
      .wd_hi (lane_wd[HI]),
      .wd_lo (lane_wd[HI+1]),
      .q_hi  (lanes[HI]),
      .q_lo  (lanes[HI+1])
    );
  end

  rf_refresh #(.W(BYTE_W)) u_ir (
    .clk   (clk),
    .rst_n (rst_n),
    .i_we  (lane_we[L_I]),
    .i_wd  (lane_wd[L_I]),
    .r_we  (lane_we[L_R]),
    .r_wd  (lane_wd[L_R]),
    .r_inc (r_inc),
    .i_q   (lanes[L_I]),
    .r_q   (lanes[L_R])
  );

  always_comb begin
    rd_pair = {lanes[pair_hi_lane(rd_pair_sel, idx_sel)],
               lanes[pair_lo_lane(rd_pair_sel, idx_sel)]};
    rd_byte = lanes[byte_lane(rd_byte_sel, idx_sel)];
  end

  // R12
  pair_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pw_en && !bw_en && !xchg_af && !xchg_exx && !r_inc &&
     rd_pair_sel == pw_sel) |=>
    (rd_pair_sel != $past(rd_pair_sel) || idx_sel != $past(idx_sel) ||
     rd_pair == $past(pw_data)))
    else $error("pair write not visible");

endmodule

// File: tb/cpu_regfile_test.sv
module cpu_regfile_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  idx_sel;
  logic        xchg_af, xchg_exx, pw_en, bw_en, r_inc;
  logic [2:0]  pw_sel, rd_pair_sel;
  logic [15:0] pw_data, rd_pair;
  logic [3:0]  bw_sel, rd_byte_sel;
  logic [7:0]  bw_data, rd_byte;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] m [20];
  logic [7:0] a [8];

  always #5 clk = ~clk;

  cpu_regfile uut (
    .clk(clk), .rst_n(rst_n), .idx_sel(idx_sel), .xchg_af(xchg_af),
    .xchg_exx(xchg_exx), .pw_en(pw_en), .pw_sel(pw_sel), .pw_data(pw_data),
    .bw_en(bw_en), .bw_sel(bw_sel), .bw_data(bw_data), .r_inc(r_inc),
    .rd_pair_sel(rd_pair_sel), .rd_pair(rd_pair),
    .rd_byte_sel(rd_byte_sel), .rd_byte(rd_byte)
  );

  function automatic int xy(input int idx);
    return (idx == 0) ? 6 : (idx == 1) ? 8 : 10;
  endfunction

  function automatic int hl_of(input int code, input int idx);
    case (code)
      0: return 0;
      1: return 2;
      2: return 4;
      3: return xy(idx);
      4: return 12;
      5: return 14;
      6: return 16;
      default: return 18;
    endcase
  endfunction

  function automatic int bl_of(input int code, input int idx);
    if (code < 6) return code;
    if (code == 6) return xy(idx);
    if (code == 7) return xy(idx) + 1;
    return code + 4;
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    for (int p = 0; p < 8; p++) begin
      for (int ix = 0; ix < ((p == 3) ? 4 : 1); ix++) begin
        rd_pair_sel = 3'(p);
        idx_sel = 2'(ix);
        #1;
        chk(tag, rd_pair, {m[hl_of(p, ix)], m[hl_of(p, ix) + 1]});
      end
    end
    for (int b = 0; b < 16; b++) begin
      for (int ix = 0; ix < ((b == 6 || b == 7) ? 4 : 1); ix++) begin
        rd_byte_sel = 4'(b);
        idx_sel = 2'(ix);
        #1;
        chk(tag, {8'h00, rd_byte}, {8'h00, m[bl_of(b, ix)]});
      end
    end
  endtask

  task automatic do_op(input bit xa, input bit xe, input bit pe, input int ps,
                       input logic [15:0] pd, input bit be, input int bs,
                       input logic [7:0] bd, input int ix, input bit inc);
    bit rw;
    logic [7:0] t;
    @(negedge clk);
    xchg_af = xa; xchg_exx = xe; pw_en = pe; pw_sel = 3'(ps); pw_data = pd;
    bw_en = be; bw_sel = 4'(bs); bw_data = bd; idx_sel = 2'(ix); r_inc = inc;
    // model: exchange first, then pair write, then byte write, then step
    rw = 1'b0;
    if (xa) for (int i = 0; i < 2; i++) begin t = m[i]; m[i] = a[i]; a[i] = t; end
    if (xe) for (int i = 2; i < 8; i++) begin t = m[i]; m[i] = a[i]; a[i] = t; end
    if (pe) begin
      m[hl_of(ps, ix)] = pd[15:8];
      m[hl_of(ps, ix) + 1] = pd[7:0];
      if (hl_of(ps, ix) == 18) rw = 1'b1;
    end
    if (be) begin
      m[bl_of(bs, ix)] = bd;
      if (bl_of(bs, ix) == 19) rw = 1'b1;
    end
    if (inc && !rw) m[19] = {m[19][7], m[19][6:0] + 7'd1};
    @(posedge clk);
    #1;
    xchg_af = 0; xchg_exx = 0; pw_en = 0; bw_en = 0; r_inc = 0;
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    rst_n = 0; idx_sel = 0; xchg_af = 0; xchg_exx = 0; pw_en = 0; pw_sel = 0;
    pw_data = 0; bw_en = 0; bw_sel = 0; bw_data = 0; r_inc = 0;
    rd_pair_sel = 0; rd_byte_sel = 0;
    for (int i = 0; i < 20; i++) m[i] = 8'h00;
    for (int i = 0; i < 8; i++) a[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    check_all("R1");
    do_op(1, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    check_all("R1");

    // R2: every pair code
    for (int p = 0; p < 8; p++) do_op(0, 0, 1, p, 16'h1000 * 16'(p + 1) + 16'h0a5 + 16'(p), 0, 0, 0, 0, 0);
    check_all("R2");
    // R12: written pair visible in the next cycle
    do_op(0, 0, 1, 4, 16'hBEEF, 0, 0, 0, 0, 0);
    rd_pair_sel = 3'd4; #1;
    chk("R12", rd_pair, 16'hBEEF);
    // R4: indexed slot through every selector value
    for (int ix = 0; ix < 4; ix++) do_op(0, 0, 1, 3, 16'h3300 + 16'(ix * 17), 0, 0, 0, ix, 0);
    do_op(0, 0, 0, 0, 0, 1, 6, 8'h6D, 1, 0);
    do_op(0, 0, 0, 0, 0, 1, 7, 8'h7E, 2, 0);
    check_all("R4");
    // R3: every byte code, other byte kept
    for (int b = 0; b < 16; b++) do_op(0, 0, 0, 0, 0, 1, b, 8'hC0 + 8'(b), 0, 0);
    check_all("R3");
    // R9: all flag bits stored
    do_op(0, 0, 0, 0, 0, 1, 1, 8'hFF, 0, 0);
    rd_byte_sel = 4'd1; #1;
    chk("R9", {8'h00, rd_byte}, 16'h00FF);
    check_all("R9");
    // distinct alternate contents
    do_op(1, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    for (int p = 0; p < 4; p++) do_op(0, 0, 1, p, 16'h9182 + 16'(p * 4369), 0, 0, 0, 0, 0);
    do_op(1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    check_all("R5");
    do_op(0, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    check_all("R6");
    do_op(1, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    check_all("R7");
    // R8: exchange plus write in one cycle
    do_op(1, 0, 0, 0, 0, 1, 0, 8'h5A, 0, 0);
    check_all("R8");
    do_op(0, 1, 1, 3, 16'h4C4D, 0, 0, 0, 0, 0);
    check_all("R8");
    do_op(1, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    check_all("R8");
    // R10: refresh wrap, bit 7 kept, write wins
    do_op(0, 0, 0, 0, 0, 1, 15, 8'h7F, 0, 0);
    do_op(0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    rd_byte_sel = 4'd15; #1;
    chk("R10", {8'h00, rd_byte}, 16'h0000);
    do_op(0, 0, 0, 0, 0, 1, 15, 8'hFF, 0, 0);
    do_op(0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    rd_byte_sel = 4'd15; #1;
    chk("R10", {8'h00, rd_byte}, 16'h0080);
    do_op(0, 0, 0, 0, 0, 1, 15, 8'h33, 0, 1);
    rd_byte_sel = 4'd15; #1;
    chk("R10", {8'h00, rd_byte}, 16'h0033);
    do_op(0, 0, 1, 7, 16'h12FF, 0, 0, 0, 0, 1);
    check_all("R10");
    // R11: byte write beats pair write on shared byte
    do_op(0, 0, 1, 1, 16'h1111, 1, 2, 8'h22, 0, 0);
    rd_pair_sel = 3'd1; #1;
    chk("R11", rd_pair, 16'h2211);
    do_op(0, 0, 1, 3, 16'hABCD, 1, 7, 8'hEE, 2, 0);
    check_all("R11");

    // random mix
    for (int n = 0; n < 400; n++) begin
      do_op(($urandom % 4) == 0, ($urandom % 4) == 0, ($urandom % 2) == 1,
            int'($urandom % 8), 16'($urandom), ($urandom % 2) == 1,
            int'($urandom % 16), 8'($urandom), int'($urandom % 4),
            ($urandom % 3) == 0);
      check_all("R2");
    end

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule